// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block watches an already-decoded serial receive stream and keeps three live status indications. Each received bit comes in on `bit_in`, marked by a one-cycle `bit_valid` strobe. Every bit-time register advances only on strobed cycles. The block reports whether HDLC flag octets are arriving and whether the line is idle, which means a long run of ones. It also passes through the carrier indication produced by an upstream clock-recovery stage.

Flag detection hunts bit by bit until the last eight bits equal the flag pattern. It then holds the indication for a fixed eight-bit window and tests that whole window as one octet. A second flag extends the hold. Anything else drops the indication, and the bit-by-bit hunt starts again. The idle indication needs fifteen consecutive ones and is dropped by any single zero.

The three indications are presented as one read-only status byte. Its upper five bits always read zero.

Top module: `hdlc_line_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears the bit history, the window and run counters, and the flag and idle indications. With `carrier_in` low, `status_byte` reads 0x00 after reset.
- R2: `status_byte[7:3]` always reads 0.
- R3: The flag indication is `status_byte[2]`. It is set on the strobed bit that makes the most recent eight bits equal 0x7E, with the earliest of those bits as the MSB. It is visible the cycle after that strobe.
- R4: The history counts as valid only after eight strobed bits since reset. A pattern formed partly from the reset contents of the history never sets the flag.
- R5: Once set, the flag stays set for the next eight strobed bits. If those eight bits are not 0x7E, the flag clears on the eighth of them.
- R6: If the eight-bit hold window is itself 0x7E, the flag stays set for a further eight-bit window.
- R7: While the flag is clear, the comparison is made on every strobed bit, so a flag at any bit offset is found.
- R8: The idle indication is `status_byte[0]`. It sets on the 15th consecutive strobed one and not before.
- R9: A single strobed zero clears the idle indication and restarts the run count from zero.
- R10: The run counter saturates, so idle stays set through an arbitrarily long run of ones.
- R11: `status_byte[1]` equals `carrier_in` in the same cycle.
- R12: Cycles without `bit_valid` change neither the flag nor the idle indication, and they do not advance the hold window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe marking a received bit |
| bit_in | input | 1 | Received, decoded data bit |
| carrier_in | input | 1 | Carrier indication from clock recovery |
| status_byte | output | 8 | {5'b0, flag, carrier, idle} |

## Verification
The carrier bit is combinational, so it is checked a fraction of a cycle after `carrier_in` changes, within the same cycle. The flag and idle bits each pass through one register. They are due on the cycle that follows the rising edge on which their bit's strobe is sampled. The bench therefore drives each strobe for exactly one cycle from a falling edge and reads the status at the next falling edge. That places every check half a cycle after the edge that updates the result. Strobe-free gaps are inserted between bits so that hold and idle state must survive cycles that carry no bit.

// File: rtl/hdlc_line_monitor.sv
`timescale 1ns/1ps
module hdlc_line_monitor #(
  parameter int FLAG_W = 8,
  parameter logic [FLAG_W-1:0] FLAG_PATTERN = 8'h7E,
  parameter int IDLE_RUN = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       carrier_in,
  output logic [7:0] status_byte
);

  localparam int CNT_W  = $clog2(FLAG_W);
  localparam int RUN_W  = $clog2(IDLE_RUN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FLAG_W - 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(IDLE_RUN);

  logic [FLAG_W-1:0] hist;
  logic [FLAG_W-1:0] hist_next;
  logic [CNT_W-1:0]  fill;
  logic [CNT_W-1:0]  win;
  logic [RUN_W-1:0]  run;
  logic              holding;
  logic              full_now;
  logic              match;
  logic              idle;

  assign hist_next = {hist[FLAG_W-2:0], bit_in};
  assign full_now  = (fill == LAST);
  assign match     = full_now && (hist_next == FLAG_PATTERN);
  assign idle      = (run == RUN_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      fill    <= '0;
      win     <= '0;
      run     <= '0;
      holding <= 1'b0;
    end else if (bit_valid) begin
      hist <= hist_next;
      if (!full_now) fill <= fill + 1'b1;

      if (!holding) begin
        if (match) begin
          holding <= 1'b1;
          win     <= '0;
        end
      end else if (win == LAST) begin
        win     <= '0;
        holding <= match;
      end else begin
        win <= win + 1'b1;
      end

      if (!bit_in)             run <= '0;
      else if (run != RUN_TOP) run <= run + 1'b1;
    end
  end

  assign status_byte = {5'b00000, holding, carrier_in, idle};

endmodule

// File: rtl/hdlc_line_monitor_chk.sv
`timescale 1ns/1ps
module hdlc_line_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       bit_in,
  input logic       carrier_in,
  input logic [7:0] status_byte
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (status_byte[2] == 1'b0 && status_byte[0] == 1'b0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_byte[7:3] == 5'b0);

  a_r3_flag_rise_on_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(status_byte[2]) |-> $past(bit_valid));

  a_r8_idle_rise_on_one: assert property (@(posedge clk) disable iff (rst)
    $rose(status_byte[0]) |-> $past(bit_valid && bit_in));

  a_r9_zero_clears_idle: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in) |=> !status_byte[0]);

  a_r11_carrier_live: assert property (@(posedge clk) disable iff (rst)
    status_byte[1] == carrier_in);

  a_r12_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(status_byte[2]) && $stable(status_byte[0])));

endmodule

bind hdlc_line_monitor hdlc_line_monitor_chk u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
  .carrier_in(carrier_in), .status_byte(status_byte)
);

// File: tb/test_hdlc_line_monitor.sv
`timescale 1ns/1ps
module test_hdlc_line_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic carrier_in = 1'b0;
  logic [7:0] status_byte;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hdlc_line_monitor i_hdlc_line_monitor (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .carrier_in(carrier_in), .status_byte(status_byte)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_octet(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    carrier_in = 1'b0;
    do_reset();
    check(status_byte, 8'h00, "R1 reset value");
    check({7'b0, status_byte[7:3] != 0}, 8'h00, "R2 reserved bits");
  endtask

  task automatic t_partial_history();
    do_reset();
    // seven bits that form 0x7E only if the reset zeros were counted
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    check({7'b0, status_byte[2]}, 8'h00, "R4 no match on reset history");
    send_bit(1'b0);
    check({7'b0, status_byte[2]}, 8'h00, "R4 eighth bit not a flag");
  endtask

  task automatic t_flag_hold_clear();
    do_reset();
    for (int i = 7; i >= 1; i--) send_bit(FLAG7[i]);
    check({7'b0, status_byte[2]}, 8'h00, "R3 flag not yet complete");
    send_bit(FLAG7[0]);
    check({7'b0, status_byte[2]}, 8'h01, "R3 flag set after 0x7E");
    for (int i = 0; i < 7; i++) begin
      send_bit(1'b0);
      check({7'b0, status_byte[2]}, 8'h01, "R5 flag held inside window");
    end
    send_bit(1'b0);
    check({7'b0, status_byte[2]}, 8'h00, "R5 flag cleared after non-flag window");
  endtask

  localparam logic [7:0] FLAG7 = 8'h7E;

  task automatic t_flag_extend();
    do_reset();
    send_octet(FLAG7);
    send_octet(FLAG7);
    check({7'b0, status_byte[2]}, 8'h01, "R6 flag after second flag");
    for (int i = 7; i >= 1; i--) send_bit(1'(8'h55 >> i));
    check({7'b0, status_byte[2]}, 8'h01, "R6 extended window still held");
    send_bit(1'b1);
    check({7'b0, status_byte[2]}, 8'h00, "R6 cleared after extended window");
  endtask

  task automatic t_unaligned();
    do_reset();
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 7; i >= 1; i--) send_bit(FLAG7[i]);
    check({7'b0, status_byte[2]}, 8'h00, "R7 no flag before completion");
    send_bit(FLAG7[0]);
    check({7'b0, status_byte[2]}, 8'h01, "R7 flag found at offset 3");
  endtask

  task automatic t_idle();
    do_reset();
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    check({7'b0, status_byte[0]}, 8'h00, "R8 idle not set at 14 ones");
    send_bit(1'b1);
    check({7'b0, status_byte[0]}, 8'h01, "R8 idle set at 15 ones");
    send_bit(1'b0);
    check({7'b0, status_byte[0]}, 8'h00, "R9 single zero clears idle");
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    check({7'b0, status_byte[0]}, 8'h00, "R9 run restarted from zero");
    send_bit(1'b1);
    check({7'b0, status_byte[0]}, 8'h01, "R9 idle again after 15 ones");
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    check({7'b0, status_byte[0]}, 8'h01, "R10 idle held through long run");
    send_bit(1'b0);
    check({7'b0, status_byte[0]}, 8'h00, "R10 saturated run cleared by zero");
  endtask

  task automatic t_carrier();
    @(negedge clk);
    carrier_in = 1'b1;
    #1;
    check({7'b0, status_byte[1]}, 8'h01, "R11 carrier high");
    check({3'b0, status_byte[7:3]}, 8'h00, "R2 reserved with carrier");
    carrier_in = 1'b0;
    #0.5;
    check({7'b0, status_byte[1]}, 8'h00, "R11 carrier low");
  endtask

  task automatic t_quiet();
    do_reset();
    for (int i = 0; i < 15; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 6; i >= 0; i--) send_bit(FLAG7[i]);
    check({6'b0, status_byte[2], status_byte[0]}, 8'h02, "R12 flag set, idle clear");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      bit_in = i[0];
    end
    check({6'b0, status_byte[2], status_byte[0]}, 8'h02, "R12 no change without strobe");
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    check({7'b0, status_byte[2]}, 8'h01, "R12 window not advanced by gap");
    send_bit(1'b1);
    check({7'b0, status_byte[2]}, 8'h00, "R12 window closes on eighth bit");
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_partial_history();
    t_flag_hold_clear();
    t_flag_extend();
    t_unaligned();
    t_idle();
    t_carrier();
    t_quiet();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule